// File: doc/BRIEF.md
# Memory Bank Remapping Controller

This block sits between a PC/AT-class processor's memory cycles and the DRAM array. Each CPU address is compared against three bank windows. Every window has a CPU start address, a physical start address and a length. An address that lands in a window is translated to a DRAM word address and a pair of byte lanes. An address outside every window is flagged as a miss. The window table is not written by software. It is preset from a static input that gives the installed memory in KiB. Several small configurations use non-identity windows, so the RAM sits where firmware expects it.

Three byte-wide configuration registers are reached through an 8-bit I/O port interface. One bit of the first register drives an alternate A20 gate enable. One bit of the second register collapses the map to a single low window of 256 KiB. Each translated access is also checked against the installed memory size. Any part that lies past the end of memory is never sent to DRAM.

Top module: `bank_remap`

## Requirements
- R1: I/O port 0x00A4 selects register 0, port 0x00A5 selects register 1 and port 0x00AB selects register 2. All three are 8 bits wide, reset to 0x00 and read back the value last written. A read of any other port returns 0xFF. Read data appears on `ioRdData` one cycle after the read strobe.
- R2: `a20Alt` equals bit 6 of register 0. It takes a new value on the clock edge that completes the write to port 0x00A4.
- R3: While bit 0 of register 1 is 1, the only active window is bank 0, resized to CPU 0x00000–0x3FFFF. Banks 1 and 2 never match in this mode. Clearing the bit restores every bank's configured window.
- R4: For an access inside a window, the physical byte address is the CPU address minus the window's CPU start, plus its physical start. DRAM receives this address divided by two on `dramAddr`, one cycle after `cpuReq`.
- R5: An access whose physical address is not below the installed size (`memSizeKb` × 1024) raises no `dramReq`. Such a byte read returns 0x00FF on `cpuRdData` and such a word read returns 0xFFFF. `cpuMiss` stays 0 for it.
- R6: An access outside every enabled window raises `cpuMiss` and no `dramReq`. A bank of length zero never matches. With no request, neither `cpuMiss` nor `dramReq` is raised.
- R7: At 640 KiB, and for any size not listed in R8–R10, CPU 0x00000–0x9FFFF maps to itself. Above 640 KiB in this layout, bank 2 maps CPU 0x100000 to physical 0xA0000, with a length of the size minus 640 KiB.
- R8: At 1024 KiB, CPU 0x00000–0x7FFFF maps to itself and CPU 0x100000–0x17FFFF maps to physical 0x80000.
- R9: At 768 KiB and 896 KiB, CPU 0x00000–0x9FFFF maps to itself. CPU 0x100000 also maps to physical 0x80000, for 128 KiB at 768 KiB and for 256 KiB at 896 KiB.
- R10: At 256 KiB, CPU 0x00000–0x3FFFF maps to itself through two 128 KiB banks. At 384 KiB, CPU 0x00000–0x5FFFF maps to itself through a 128 KiB bank 0 and a 256 KiB bank 2 starting at 0x20000. At 512 KiB, only CPU 0x00000–0x7FFFF maps, as identity.
- R11: Byte order is little-endian. A word access drives `dramByteEn` = 2'b11, ignores CPU address bit 0 and carries the low byte on `dramWrData[7:0]`. A byte access at an even address drives 2'b01 and at an odd address 2'b10. A byte write copies its byte onto both lanes. A byte read returns the selected lane in `cpuRdData[7:0]` with the upper byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memSizeKb | input | 15 | Installed memory in KiB, held static |
| ioAddr | input | 16 | I/O port address |
| ioWr | input | 1 | I/O write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data, one cycle after `ioRd` |
| a20Alt | output | 1 | Alternate A20 gate enable |
| cpuReq | input | 1 | CPU memory access strobe |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuWord | input | 1 | 1 = 16-bit word, 0 = byte |
| cpuAddr | input | 24 | CPU byte address |
| cpuWrData | input | 16 | Write data (byte writes use bits 7:0) |
| rspValid | output | 1 | Response cycle for the access of the previous cycle |
| cpuMiss | output | 1 | Access matched no enabled window |
| cpuRdData | output | 16 | Read data for the access in the response cycle |
| dramReq | output | 1 | DRAM access strobe |
| dramWe | output | 1 | DRAM write |
| dramAddr | output | 23 | DRAM word address |
| dramByteEn | output | 2 | DRAM byte lane enables |
| dramWrData | output | 16 | DRAM write data |
| dramRdData | input | 16 | DRAM read data for `dramAddr`, combinational |

## Verification
Window decode and range checking sit in one registered stage. `rspValid`, `cpuMiss` and every DRAM strobe are due one cycle after `cpuReq`. `cpuRdData` is formed in that same response cycle from `dramRdData`. Register reads are due on `ioRdData` one cycle after `ioRd`, and `a20Alt` and the low-only mode take effect from the cycle after an I/O write. The bench drives every stimulus on a falling edge and samples on the next falling edge, so each result is read exactly one register stage later. It never issues a read in the same cycle as a write to the same register.

// File: rtl/bank_remap_pkg.sv
package bank_remap_pkg;

  localparam int NUM_BANKS = 3;
  localparam logic [31:0] LOW_ONLY_BYTES = 32'h0004_0000;

  typedef struct packed {
    logic [31:0] cpuBase;
    logic [31:0] physBase;
    logic [31:0] winSize;
  } bankWin_t;

  typedef bankWin_t [NUM_BANKS-1:0] bankSet_t;

  typedef struct packed {
    logic a20Alt;
    logic lowOnly;
  } ctrlStrobes_t;

  function automatic bankWin_t mkWin(input logic [31:0] cpuBase,
                                     input logic [31:0] physBase,
                                     input logic [31:0] winSize);
    bankWin_t w;
    w.cpuBase  = cpuBase;
    w.physBase = physBase;
    w.winSize  = winSize;
    return w;
  endfunction

  // Static window presets selected by the installed size in KiB.
  function automatic bankSet_t presetWindows(input logic [31:0] memKb);
    bankSet_t s;
    s = '0;
    case (memKb)
      32'd256: begin
        s[0] = mkWin(32'h0, 32'h0, 32'h2_0000);
        s[1] = mkWin(32'h2_0000, 32'h2_0000, 32'h2_0000);
      end
      32'd384: begin
        s[0] = mkWin(32'h0, 32'h0, 32'h2_0000);
        s[2] = mkWin(32'h2_0000, 32'h2_0000, 32'h4_0000);
      end
      32'd512: begin
        s[0] = mkWin(32'h0, 32'h0, 32'h8_0000);
      end
      32'd768, 32'd896: begin
        s[0] = mkWin(32'h0, 32'h0, 32'h8_0000);
        s[1] = mkWin(32'h8_0000, 32'h8_0000, 32'h2_0000);
        s[2] = mkWin(32'h10_0000, 32'h8_0000,
                     (memKb == 32'd768) ? 32'h2_0000 : 32'h4_0000);
      end
      32'd1024: begin
        s[0] = mkWin(32'h0, 32'h0, 32'h8_0000);
        s[1] = mkWin(32'h10_0000, 32'h8_0000, 32'h8_0000);
      end
      default: begin
        s[0] = mkWin(32'h0, 32'h0, 32'h8_0000);
        s[1] = mkWin(32'h8_0000, 32'h8_0000, 32'h2_0000);
        if (memKb > 32'd640)
          s[2] = mkWin(32'h10_0000, 32'hA_0000, (memKb << 10) - 32'hA_0000);
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import bank_remap_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] PORT_GATE = 16'h00A4,
  parameter logic [IO_AW-1:0] PORT_MAP  = 16'h00A5,
  parameter logic [IO_AW-1:0] PORT_AUX  = 16'h00AB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic             ioWr,
  input  logic             ioRd,
  input  logic [7:0]       ioWrData,
  output logic [7:0]       ioRdData,
  output ctrlStrobes_t     ctl
);

  localparam int NUM_REGS = 3;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][7:0] cfgRegs;
  logic [IDX_W-1:0]         selIdx;
  logic                     selValid;

  always_comb begin
    selValid = 1'b1;
    selIdx   = '0;
    case (ioAddr)
      PORT_GATE: selIdx = IDX_W'(0);
      PORT_MAP:  selIdx = IDX_W'(1);
      PORT_AUX:  selIdx = IDX_W'(2);
      default:   selValid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgRegs  <= '0;
      ioRdData <= '0;
    end else begin
      if (ioWr && selValid) cfgRegs[selIdx] <= ioWrData;
      if (ioRd) ioRdData <= selValid ? cfgRegs[selIdx] : 8'hFF;
    end
  end

  assign ctl.a20Alt  = cfgRegs[0][6];
  assign ctl.lowOnly = cfgRegs[1][0];

  // R2: gate output follows bit 6 of the written byte
  p_a20_tracks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == PORT_GATE) |=> (ctl.a20Alt == $past(ioWrData[6])));

  // R1: unmapped ports read as all ones
  p_unmapped_port_ff_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr != PORT_GATE && ioAddr != PORT_MAP && ioAddr != PORT_AUX)
      |=> (ioRdData == 8'hFF));

  // R3: mode bit follows bit 0 of the written byte
  p_low_mode_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == PORT_MAP) |=> (ctl.lowOnly == $past(ioWrData[0])));

endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import bank_remap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic [SIZE_W-1:0] memSizeKb,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              cpuWord,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [15:0]       cpuWrData,
  output logic              rspValid,
  output logic              cpuMiss,
  output logic [15:0]       cpuRdData,
  output logic              dramReq,
  output logic              dramWe,
  output logic [ADDR_W-2:0] dramAddr,
  output logic [1:0]        dramByteEn,
  output logic [15:0]       dramWrData,
  input  logic [15:0]       dramRdData
);

  bankSet_t             cfgWin;
  bankWin_t             effWin [NUM_BANKS];
  logic [NUM_BANKS-1:0] winMatch;
  logic [31:0]          addr32;
  logic [31:0]          memBytes32;
  logic [31:0]          selBase;
  logic [31:0]          selPhys;
  logic [31:0]          phys32;
  logic                 hit;
  logic                 fits;
  logic                 grant;

  logic                 rspWord;
  logic                 rspOdd;
  logic                 rspBlocked;

  assign cfgWin     = presetWindows(32'(memSizeKb));
  assign addr32     = 32'(cpuAddr);
  assign memBytes32 = 32'(memSizeKb) << 10;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_win
    always_comb begin
      effWin[g] = cfgWin[g];
      if (ctl.lowOnly) begin
        if (g == 0) effWin[g].winSize = LOW_ONLY_BYTES;
        else        effWin[g].winSize = '0;
      end
    end
    assign winMatch[g] = (effWin[g].winSize != '0) &&
                         (addr32 >= effWin[g].cpuBase) &&
                         (addr32 < effWin[g].cpuBase + effWin[g].winSize);
  end

  // Lowest-numbered matching bank wins.
  always_comb begin
    hit     = 1'b0;
    selBase = '0;
    selPhys = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (winMatch[i]) begin
        hit     = 1'b1;
        selBase = effWin[i].cpuBase;
        selPhys = effWin[i].physBase;
      end
    end
  end

  assign phys32 = addr32 - selBase + selPhys;
  assign fits   = (phys32[31:ADDR_W] == '0) && (phys32 < memBytes32);
  assign grant  = hit && fits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      cpuMiss    <= 1'b0;
      dramReq    <= 1'b0;
      dramWe     <= 1'b0;
      dramAddr   <= '0;
      dramByteEn <= '0;
      dramWrData <= '0;
      rspWord    <= 1'b0;
      rspOdd     <= 1'b0;
      rspBlocked <= 1'b1;
    end else begin
      rspValid <= cpuReq;
      cpuMiss  <= cpuReq && !hit;
      dramReq  <= cpuReq && grant;
      dramWe   <= cpuReq && grant && cpuWe;
      if (cpuReq) begin
        dramAddr   <= phys32[ADDR_W-1:1];
        dramByteEn <= cpuWord ? 2'b11 : (phys32[0] ? 2'b10 : 2'b01);
        dramWrData <= cpuWord ? cpuWrData : {cpuWrData[7:0], cpuWrData[7:0]};
        rspWord    <= cpuWord;
        rspOdd     <= phys32[0];
        rspBlocked <= !grant;
      end
    end
  end

  always_comb begin
    if (rspBlocked)   cpuRdData = rspWord ? 16'hFFFF : 16'h00FF;
    else if (rspWord) cpuRdData = dramRdData;
    else              cpuRdData = {8'h00, rspOdd ? dramRdData[15:8] : dramRdData[7:0]};
  end

  // R6: no response strobes without a request
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |=> (!dramReq && !cpuMiss));

  // R3: nothing above the low window is reachable in low-only mode
  p_low_only_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && ctl.lowOnly && addr32 >= LOW_ONLY_BYTES) |=> (cpuMiss && !dramReq));

  // R5: DRAM is never addressed past the installed size
  p_range_guard_r5: assert property (@(posedge clk) disable iff (!rstN)
    dramReq |-> ((32'(dramAddr) << 1) < memBytes32));

  // R5: a refused access reads as all ones in its low byte
  p_refused_read_ff_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !dramReq && !dramWe) |-> (cpuRdData[7:0] == 8'hFF));

endmodule

// File: rtl/bank_remap.sv
module bank_remap
  import bank_remap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 15,
  parameter int IO_AW  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SIZE_W-1:0] memSizeKb,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic              a20Alt,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              cpuWord,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [15:0]       cpuWrData,
  output logic              rspValid,
  output logic              cpuMiss,
  output logic [15:0]       cpuRdData,
  output logic              dramReq,
  output logic              dramWe,
  output logic [ADDR_W-2:0] dramAddr,
  output logic [1:0]        dramByteEn,
  output logic [15:0]       dramWrData,
  input  logic [15:0]       dramRdData
);

  ctrlStrobes_t ctl;

  remap_ctrl #(.IO_AW(IO_AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ioAddr   (ioAddr),
    .ioWr     (ioWr),
    .ioRd     (ioRd),
    .ioWrData (ioWrData),
    .ioRdData (ioRdData),
    .ctl      (ctl)
  );

  remap_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .memSizeKb  (memSizeKb),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .cpuWord    (cpuWord),
    .cpuAddr    (cpuAddr),
    .cpuWrData  (cpuWrData),
    .rspValid   (rspValid),
    .cpuMiss    (cpuMiss),
    .cpuRdData  (cpuRdData),
    .dramReq    (dramReq),
    .dramWe     (dramWe),
    .dramAddr   (dramAddr),
    .dramByteEn (dramByteEn),
    .dramWrData (dramWrData),
    .dramRdData (dramRdData)
  );

  assign a20Alt = ctl.a20Alt;

endmodule

// File: tb/bank_remap_tb.sv
`timescale 1ns/1ps
module bank_remap_tb;

  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] memSizeKb = 15'd640;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        a20Alt;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic        cpuWord = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic [15:0] cpuWrData = '0;
  logic        rspValid;
  logic        cpuMiss;
  logic [15:0] cpuRdData;
  logic        dramReq;
  logic        dramWe;
  logic [22:0] dramAddr;
  logic [1:0]  dramByteEn;
  logic [15:0] dramWrData;
  logic [15:0] dramRdData;

  int  nChk = 0;
  int  nBad = 0;
  int  memKb = 640;
  bit  lowModel = 1'b0;
  bit  done = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  bank_remap u_dut (
    .clk(clk), .rstN(rstN), .memSizeKb(memSizeKb),
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .a20Alt(a20Alt),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuWord(cpuWord), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .rspValid(rspValid), .cpuMiss(cpuMiss),
    .cpuRdData(cpuRdData), .dramReq(dramReq), .dramWe(dramWe),
    .dramAddr(dramAddr), .dramByteEn(dramByteEn), .dramWrData(dramWrData),
    .dramRdData(dramRdData)
  );

  function automatic logic [15:0] patOf(input int wa);
    return {wa[7:0] ^ 8'hC3, wa[15:8] ^ wa[7:0] ^ 8'h5E};
  endfunction

  assign dramRdData = patOf(int'(dramAddr));

  // Reference window table written from R3 and R7-R10.
  function automatic void refMap(input int kb, input bit low, input int addr,
                                 output bit hit, output int phys);
    int b[3];
    int p[3];
    int s[3];
    for (int i = 0; i < 3; i++) begin b[i] = 0; p[i] = 0; s[i] = 0; end
    if (kb == 256) begin
      s[0] = 'h20000; b[1] = 'h20000; p[1] = 'h20000; s[1] = 'h20000;
    end else if (kb == 384) begin
      s[0] = 'h20000; b[2] = 'h20000; p[2] = 'h20000; s[2] = 'h40000;
    end else if (kb == 512) begin
      s[0] = 'h80000;
    end else if (kb == 1024) begin
      s[0] = 'h80000; b[1] = 'h100000; p[1] = 'h80000; s[1] = 'h80000;
    end else begin
      s[0] = 'h80000; b[1] = 'h80000; p[1] = 'h80000; s[1] = 'h20000;
      if (kb == 768) begin b[2] = 'h100000; p[2] = 'h80000; s[2] = 'h20000; end
      else if (kb == 896) begin b[2] = 'h100000; p[2] = 'h80000; s[2] = 'h40000; end
      else if (kb > 640) begin b[2] = 'h100000; p[2] = 'hA0000; s[2] = kb * 1024 - 'hA0000; end
    end
    if (low) begin s[0] = 'h40000; s[1] = 0; s[2] = 0; end
    hit = 1'b0;
    phys = 0;
    for (int i = 2; i >= 0; i--) begin
      if (s[i] != 0 && addr >= b[i] && addr < b[i] + s[i]) begin
        hit = 1'b1;
        phys = addr - b[i] + p[i];
      end
    end
  endfunction

  task automatic check(input string tag, input string what,
                       input longint got, input longint exp);
    nChk++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic setSize(input int kb);
    @(negedge clk);
    memKb = kb;
    memSizeKb = 15'(kb);
  endtask

  task automatic ioWrite(input logic [15:0] port, input logic [7:0] val);
    @(negedge clk);
    ioAddr = port; ioWrData = val; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
    if (port == 16'h00A5) lowModel = val[0];
  endtask

  task automatic ioReadCheck(input string tag, input logic [15:0] port,
                             input logic [7:0] exp);
    @(negedge clk);
    ioAddr = port; ioRd = 1'b1;
    @(negedge clk);
    ioRd = 1'b0;
    check(tag, "ioRdData", ioRdData, exp);
  endtask

  task automatic doAccess(input string tag, input bit we, input bit word,
                          input int addr, input logic [15:0] wd);
    bit hit;
    int phys;
    bit reqE;
    logic [15:0] pat;
    logic [15:0] expRd;
    refMap(memKb, lowModel, addr, hit, phys);
    reqE = hit && (phys < memKb * 1024);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuWord = word; cpuAddr = addr[23:0]; cpuWrData = wd;
    @(negedge clk);
    cpuReq = 1'b0;
    check(tag, "rspValid", rspValid, 1);
    check(tag, "cpuMiss", cpuMiss, !hit);
    check(tag, "dramReq", dramReq, reqE);
    if (reqE) begin
      check(tag, "dramWe", dramWe, we);
      check(tag, "dramAddr", dramAddr, phys >> 1);
      check(tag, "dramByteEn", dramByteEn, word ? 2 'b11 : (phys[0] ? 2'b10 : 2'b01));
      if (we) check(tag, "dramWrData", dramWrData, word ? wd : {wd[7:0], wd[7:0]});
    end
    if (!we) begin
      pat = patOf(phys >> 1);
      if (!reqE) expRd = word ? 16'hFFFF : 16'h00FF;
      else if (word) expRd = pat;
      else expRd = {8'h00, phys[0] ? pat[15:8] : pat[7:0]};
      check(tag, "cpuRdData", cpuRdData, expRd);
    end
  endtask

  // Explicit translation check independent of the reference table.
  task automatic expectPhys(input string tag, input int addr, input int phys);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuWord = 1'b0; cpuAddr = addr[23:0];
    @(negedge clk);
    cpuReq = 1'b0;
    check(tag, "hit", {cpuMiss, dramReq}, 2'b01);
    check(tag, "dramAddr", dramAddr, phys >> 1);
  endtask

  task automatic expectMiss(input string tag, input int addr);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuWord = 1'b0; cpuAddr = addr[23:0];
    @(negedge clk);
    cpuReq = 1'b0;
    check(tag, "miss", {cpuMiss, dramReq}, 2'b10);
    check(tag, "missRd", cpuRdData, 16'h00FF);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  int cfgList[9] = '{256, 384, 512, 640, 768, 896, 1024, 2048, 4096};
  int edges[10] = '{'h20000, 'h40000, 'h60000, 'h80000, 'hA0000,
                    'h100000, 'h120000, 'h140000, 'h180000, 'h260000};

  initial begin
    void'($urandom(32'd20250528));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    check("R1", "reset ioRdData", ioRdData, 8'h00);
    check("R2", "reset a20Alt", a20Alt, 0);
    check("R6", "reset idle", {rspValid, cpuMiss, dramReq}, 3'b000);
    ioReadCheck("R1", 16'h00A4, 8'h00);
    ioReadCheck("R1", 16'h00A5, 8'h00);
    ioReadCheck("R1", 16'h00AB, 8'h00);

    // R1 register file and unmapped ports
    ioWrite(16'h00A4, 8'h5A);
    ioWrite(16'h00A5, 8'h3C);
    ioWrite(16'h00AB, 8'hA7);
    ioReadCheck("R1", 16'h00A4, 8'h5A);
    ioReadCheck("R1", 16'h00A5, 8'h3C);
    ioReadCheck("R1", 16'h00AB, 8'hA7);
    ioReadCheck("R1", 16'h00A6, 8'hFF);
    ioReadCheck("R1", 16'h00A3, 8'hFF);
    ioReadCheck("R1", 16'h01A4, 8'hFF);

    // R2 gate output
    ioWrite(16'h00A4, 8'hBF);
    check("R2", "a20Alt low", a20Alt, 0);
    ioWrite(16'h00A4, 8'h40);
    check("R2", "a20Alt high", a20Alt, 1);
    ioWrite(16'h00AB, 8'h00);
    check("R2", "a20Alt unaffected by aux", a20Alt, 1);

    // R7 layouts
    setSize(640);
    expectPhys("R7", 'h7FFFE, 'h7FFFE);
    expectPhys("R7", 'h9FFFF, 'h9FFFF);
    expectMiss("R7", 'hA0000);
    expectMiss("R7", 'h100000);
    setSize(2048);
    expectPhys("R7", 'h100000, 'hA0000);
    expectPhys("R7", 'h25FFFF, 'h1FFFFF);
    expectMiss("R6", 'h260000);
    // R8
    setSize(1024);
    expectPhys("R8", 'h100000, 'h80000);
    expectPhys("R8", 'h17FFFF, 'hFFFFF);
    expectMiss("R8", 'h80000);
    expectMiss("R8", 'h180000);
    // R9
    setSize(768);
    expectPhys("R9", 'h100000, 'h80000);
    expectPhys("R9", 'h11FFFF, 'h9FFFF);
    expectMiss("R9", 'h120000);
    setSize(896);
    expectPhys("R9", 'h13FFFF, 'hBFFFF);
    expectMiss("R9", 'h140000);
    // R10
    setSize(384);
    expectPhys("R10", 'h1FFFF, 'h1FFFF);
    expectPhys("R10", 'h20000, 'h20000);
    expectPhys("R10", 'h5FFFF, 'h5FFFF);
    expectMiss("R10", 'h60000);
    setSize(256);
    expectPhys("R10", 'h3FFFF, 'h3FFFF);
    expectMiss("R10", 'h40000);
    setSize(512);
    expectPhys("R10", 'h7FFFF, 'h7FFFF);
    expectMiss("R10", 'h80000);

    // R3 low-only mode
    setSize(2048);
    ioWrite(16'h00A5, 8'h01);
    expectPhys("R3", 'h3FFFF, 'h3FFFF);
    expectMiss("R3", 'h40000);
    expectMiss("R3", 'h80000);
    expectMiss("R3", 'h100000);
    ioWrite(16'h00A5, 8'h00);
    expectPhys("R3", 'h100000, 'hA0000);
    expectPhys("R3", 'h7FFFF, 'h7FFFF);

    // R5 out-of-range inside a window (600 KiB = 0x96000 bytes)
    setSize(600);
    doAccess("R5", 1'b0, 1'b0, 'h96000, 16'h0);
    check("R5", "oor byte read", cpuRdData, 16'h00FF);
    doAccess("R5", 1'b0, 1'b1, 'h98000, 16'h0);
    check("R5", "oor word read", cpuRdData, 16'hFFFF);
    doAccess("R5", 1'b1, 1'b1, 'h96000, 16'h1234);
    check("R5", "oor write blocked", {dramReq, dramWe, cpuMiss}, 3'b000);
    doAccess("R5", 1'b0, 1'b0, 'h95FFF, 16'h0);
    check("R5", "last byte in range", dramReq, 1);

    // R11 lanes
    setSize(640);
    doAccess("R11", 1'b1, 1'b0, 'h1235, 16'h00AB);
    check("R11", "odd byte lanes", dramByteEn, 2'b10);
    check("R11", "byte replicated", dramWrData, 16'hABAB);
    doAccess("R11", 1'b1, 1'b0, 'h1234, 16'h0055);
    check("R11", "even byte lanes", dramByteEn, 2'b01);
    doAccess("R11", 1'b1, 1'b1, 'h1234, 16'hBEEF);
    check("R11", "word data", {dramByteEn, dramWrData}, {2'b11, 16'hBEEF});
    doAccess("R11", 1'b0, 1'b1, 'h1235, 16'h0);
    check("R11", "word ignores bit0", dramAddr, 'h1234 >> 1);
    doAccess("R11", 1'b0, 1'b0, 'h1235, 16'h0);
    check("R11", "odd byte read", cpuRdData, {8'h00, patOf('h1234 >> 1) >> 8});

    // R4 random mix against the reference table
    foreach (cfgList[c]) begin
      setSize(cfgList[c]);
      for (int n = 0; n < 250; n++) begin
        int addr;
        if ($urandom_range(0, 19) == 0)
          ioWrite(16'h00A5, {7'h0, 1'($urandom_range(0, 1))});
        if ($urandom_range(0, 1) == 0)
          addr = $urandom_range(0, 'h3FFFFF);
        else
          addr = edges[$urandom_range(0, 9)] + $urandom_range(0, 7) - 4;
        doAccess("R4", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 addr, 16'($urandom));
      end
      ioWrite(16'h00A5, 8'h00);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule